// File: doc/BRIEF.md
# Serial Slave Front-End with Transfer Pause

This block is the pin-facing half of a serial slave for a memory-like peripheral. It watches four pins: serial clock, serial data in, an active-low select and an active-low pause line. Incoming bits are assembled into bytes and handed to the command logic as a one-cycle strobe with the byte attached. Response bytes from the command logic are shifted out on a data-out pin, and a separate enable marks when that pin should be driven.

All four pins are oversampled by the system clock through a synchronizer chain, so the block and its parallel side live entirely in one clock domain. Both idle levels of the serial clock (low-idle, mode 0, and high-idle, mode 3) are accepted without configuration. Input bits are taken on the rising serial clock and output bits change after the falling serial clock, most significant bit first.

A pause freezes a transfer in mid-byte without deselecting the slave. The pause line only takes effect while the serial clock is low; an edge seen while the clock is high waits for the next low phase. Deselecting during a pause discards the partial byte and clears the pause.

Top module: `spi_hold_slave`

## Requirements
- R1: While selected and not paused, a data-in bit is captured on each rising serial clock, most significant bit first; after every eighth captured bit `rx_valid` pulses for exactly one system clock with the assembled byte on `rx_byte`.
- R2: A response byte is shifted out most significant bit first, with each later bit changing only after a falling serial clock; the first bit of a transaction is on `so` before the first rising serial clock in both mode 0 and mode 3.
- R3: In mode 3, the falling serial clock that comes before the first rising edge of a transaction does not advance the outgoing byte.
- R4: A response byte is taken from `tx_byte` when the select falls and at the falling serial clock that follows each eighth rising edge; `tx_load` pulses for one system clock each time a byte is taken, which happens only while `tx_en` is 1. If `tx_en` is 0 at that moment, `so_oe` stays 0 for the whole byte.
- R5: `so_oe` is 0 whenever `cs_n` is high, while paused, and after reset.
- R6: If `hold_n` falls while the serial clock is low, the slave pauses: `so_oe` goes to 0, serial clock and data-in activity is ignored, and the partial byte in both directions continues intact once `hold_n` rises again during a low serial clock.
- R7: If `hold_n` falls while the serial clock is high, the slave keeps driving until the serial clock next goes low; that falling edge still advances the outgoing bit, and the pause starts there.
- R8: If `hold_n` rises while the serial clock is high, the pause persists (`so_oe` stays 0) until the serial clock next goes low.
- R9: Raising `cs_n` during a pause clears the pause and the partial byte, with no `rx_valid`; the next transaction after the select falls again starts with a fresh byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples all serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock from the master |
| si | input | 1 | Serial data in |
| cs_n | input | 1 | Active-low select |
| hold_n | input | 1 | Active-low pause request |
| so | output | 1 | Serial data out value |
| so_oe | output | 1 | Drive enable for `so`; 0 means high impedance |
| rx_valid | output | 1 | One-cycle strobe: a byte was received |
| rx_byte | output | DATA_W | Received byte, valid with `rx_valid` |
| tx_byte | input | DATA_W | Next response byte from the command logic |
| tx_en | input | 1 | `tx_byte` holds a response byte to send |
| tx_load | output | 1 | One-cycle strobe: `tx_byte` was taken |

## Verification
The bench builds the block with its defaults, an eight-bit byte and a two-flop synchronizer, and runs the serial clock at twelve system clocks per period so that every synchronizer delay fits inside a half period. With that margin the bench can place pause edges deliberately in the low and in the high phase of the serial clock, in both clock modes, and observe the deferred entry and exit one half period apart. The two-flop setting also keeps the select, clock and pause paths aligned, which lets an abort by deselect during a pause be followed at once by a clean transaction.

// File: rtl/spi_hold_pkg.sv
package spi_hold_pkg;

   // Serial pin bundle, oversampled as one vector
   typedef struct packed {
      logic sck;
      logic si;
      logic cs_n;
      logic hold_n;
   } pins_t;

   localparam int PIN_W = $bits(pins_t);

   // Reset level of the synchronized pins: deselected, not paused
   localparam pins_t PINS_IDLE = '{sck: 1'b0, si: 1'b0, cs_n: 1'b1, hold_n: 1'b1};

endpackage

// File: rtl/spi_hold_sync.sv
module spi_hold_sync #(
   parameter int              W       = 4,
   parameter int              STAGES  = 2,
   parameter logic [W-1:0]    RST_VAL = '0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [W-1:0]  d,
   output logic [W-1:0]  q
);

   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [STAGES-1:0][W-1:0] st;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int k = 0; k < STAGES; k++) st[k] <= RST_VAL;
            end else begin
               st[0] <= d;
               for (int k = 1; k < STAGES; k++) st[k] <= st[k-1];
            end
         end
         assign q = st[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/spi_hold_ctrl.sv
module spi_hold_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic sck_s,
   input  logic cs_n_s,
   input  logic hold_n_s,
   output logic sck_rise,
   output logic sck_fall,
   output logic sel_start,
   output logic hold_q
);

   logic sck_d;
   logic cs_n_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_d  <= 1'b0;
         cs_n_d <= 1'b1;
         hold_q <= 1'b0;
      end else begin
         sck_d  <= sck_s;
         cs_n_d <= cs_n_s;
         // pause state only moves while the serial clock is low
         if (cs_n_s)
            hold_q <= 1'b0;
         else if (!sck_s)
            hold_q <= !hold_n_s;
      end
   end

   assign sck_rise  =  sck_s && !sck_d && !cs_n_s && !hold_q;
   assign sck_fall  = !sck_s &&  sck_d && !cs_n_s && !hold_q;
   assign sel_start =  cs_n_d && !cs_n_s;

endmodule

// File: rtl/spi_hold_shift.sv
module spi_hold_shift #(
   parameter int DATA_W = 8,
   localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sck_rise,
   input  logic              sck_fall,
   input  logic              sel_start,
   input  logic              desel,
   input  logic              si_s,
   input  logic [DATA_W-1:0] tx_byte,
   input  logic              tx_en,
   output logic              rx_valid,
   output logic [DATA_W-1:0] rx_byte,
   output logic              tx_load,
   output logic              tx_active,
   output logic [DATA_W-1:0] tx_sh,
   output logic [CNT_W-1:0]  bit_cnt
);

   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

   logic [DATA_W-1:0] rx_sh;
   logic              byte_due;   // a byte boundary awaits its falling edge

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_cnt   <= '0;
         rx_sh     <= '0;
         rx_byte   <= '0;
         rx_valid  <= 1'b0;
         tx_sh     <= '0;
         tx_load   <= 1'b0;
         tx_active <= 1'b0;
         byte_due  <= 1'b0;
      end else begin
         rx_valid <= 1'b0;
         tx_load  <= 1'b0;
         if (desel) begin
            bit_cnt   <= '0;
            rx_sh     <= '0;
            tx_active <= 1'b0;
            byte_due  <= 1'b0;
         end else if (sel_start) begin
            bit_cnt   <= '0;
            byte_due  <= 1'b0;
            tx_load   <= tx_en;
            tx_active <= tx_en;
            if (tx_en) tx_sh <= tx_byte;
         end else begin
            if (sck_rise) begin
               rx_sh <= {rx_sh[DATA_W-2:0], si_s};
               if (bit_cnt == LAST_BIT) begin
                  bit_cnt  <= '0;
                  byte_due <= 1'b1;
                  rx_valid <= 1'b1;
                  rx_byte  <= {rx_sh[DATA_W-2:0], si_s};
               end else begin
                  bit_cnt <= bit_cnt + 1'b1;
               end
            end
            if (sck_fall) begin
               if (byte_due) begin
                  byte_due  <= 1'b0;
                  tx_load   <= tx_en;
                  tx_active <= tx_en;
                  if (tx_en) tx_sh <= tx_byte;
               end else if (bit_cnt != '0) begin
                  tx_sh <= {tx_sh[DATA_W-2:0], 1'b0};
               end
            end
         end
      end
   end

endmodule

// File: rtl/spi_hold_slave.sv
module spi_hold_slave
   import spi_hold_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2,
   localparam int CNT_W      = (DATA_W > 1) ? $clog2(DATA_W) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sck,
   input  logic              si,
   input  logic              cs_n,
   input  logic              hold_n,
   output logic              so,
   output logic              so_oe,
   output logic              rx_valid,
   output logic [DATA_W-1:0] rx_byte,
   input  logic [DATA_W-1:0] tx_byte,
   input  logic              tx_en,
   output logic              tx_load
);

   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("spi_hold_slave: DATA_W must be at least 2");
      end
      if (SYNC_STAGES == 1) begin : g_bad_sync
         $error("spi_hold_slave: SYNC_STAGES must be 0 or at least 2");
      end
   endgenerate

   pins_t            pins_raw;
   pins_t            pins_s;
   logic             sck_s;
   logic             cs_n_s;
   logic             sck_rise;
   logic             sck_fall;
   logic             sel_start;
   logic             hold_q;
   logic             tx_active;
   logic [DATA_W-1:0] tx_sh;
   logic [CNT_W-1:0] bit_cnt;

   assign pins_raw = '{sck: sck, si: si, cs_n: cs_n, hold_n: hold_n};

   spi_hold_sync #(
      .W       (PIN_W),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (PINS_IDLE)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pins_raw),
      .q     (pins_s)
   );

   assign sck_s  = pins_s.sck;
   assign cs_n_s = pins_s.cs_n;

   spi_hold_ctrl u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .sck_s     (sck_s),
      .cs_n_s    (cs_n_s),
      .hold_n_s  (pins_s.hold_n),
      .sck_rise  (sck_rise),
      .sck_fall  (sck_fall),
      .sel_start (sel_start),
      .hold_q    (hold_q)
   );

   spi_hold_shift #(
      .DATA_W (DATA_W)
   ) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .sck_rise  (sck_rise),
      .sck_fall  (sck_fall),
      .sel_start (sel_start),
      .desel     (cs_n_s),
      .si_s      (pins_s.si),
      .tx_byte   (tx_byte),
      .tx_en     (tx_en),
      .rx_valid  (rx_valid),
      .rx_byte   (rx_byte),
      .tx_load   (tx_load),
      .tx_active (tx_active),
      .tx_sh     (tx_sh),
      .bit_cnt   (bit_cnt)
   );

   assign so    = tx_sh[DATA_W-1];
   assign so_oe = tx_active && !hold_q && !cs_n_s;

endmodule

// File: rtl/spi_hold_slave_chk.sv
module spi_hold_slave_chk #(
   parameter int DATA_W = 8,
   parameter int CNT_W  = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rx_valid,
   input logic              tx_load,
   input logic              so_oe,
   input logic              hold_q,
   input logic              sck_s,
   input logic              cs_n_s,
   input logic [CNT_W-1:0]  bit_cnt,
   input logic [DATA_W-1:0] tx_sh
);

   AST_RX_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> !rx_valid);                                           // R1

   AST_RX_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |-> bit_cnt == '0);                                       // R1

   AST_TX_LOAD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      tx_load |=> !tx_load);                                             // R4

   AST_NO_DRIVE_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n_s |-> !so_oe);                                                // R5

   AST_PAUSE_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_q && $past(hold_q)) |-> ($stable(bit_cnt) && $stable(tx_sh))); // R6

   AST_PAUSE_MOVES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(hold_q) |-> (!$past(sck_s) || $past(cs_n_s)));            // R7

   AST_PAUSE_CLEARED_DESEL: assert property (@(posedge clk) disable iff (!rst_n)
      $past(cs_n_s) |-> !hold_q);                                        // R9

endmodule

bind spi_hold_slave spi_hold_slave_chk #(
   .DATA_W (DATA_W),
   .CNT_W  (CNT_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .rx_valid (rx_valid),
   .tx_load  (tx_load),
   .so_oe    (so_oe),
   .hold_q   (hold_q),
   .sck_s    (sck_s),
   .cs_n_s   (cs_n_s),
   .bit_cnt  (bit_cnt),
   .tx_sh    (tx_sh)
);

// File: tb/spi_hold_slave_tb.sv
module spi_hold_slave_tb;

   localparam int CLK_PERIOD = 10;
   localparam int HALF_SCK   = 6;     // system clocks per serial half period
   localparam int DW         = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          sck = 1'b0;
   logic          si = 1'b0;
   logic          cs_n = 1'b1;
   logic          hold_n = 1'b1;
   logic          so;
   logic          so_oe;
   logic          rx_valid;
   logic [DW-1:0] rx_byte;
   logic [DW-1:0] tx_byte = '0;
   logic          tx_en = 1'b0;
   logic          tx_load;

   int errors = 0;
   int checks = 0;

   logic [DW-1:0] rx_exp_q[$];
   logic [DW-1:0] tx_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   spi_hold_slave #(.DATA_W(DW), .SYNC_STAGES(2)) u_dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .sck      (sck),
      .si       (si),
      .cs_n     (cs_n),
      .hold_n   (hold_n),
      .so       (so),
      .so_oe    (so_oe),
      .rx_valid (rx_valid),
      .rx_byte  (rx_byte),
      .tx_byte  (tx_byte),
      .tx_en    (tx_en),
      .tx_load  (tx_load)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, checks);
   endtask

   task automatic half();
      repeat (HALF_SCK) @(negedge clk);
   endtask

   // response side of the command logic: present head of queue, drop it when taken
   always @(negedge clk) begin
      if (tx_load && tx_q.size() > 0) void'(tx_q.pop_front());
      tx_en   = (tx_q.size() > 0);
      tx_byte = tx_en ? tx_q[0] : '0;
   end

   // scoreboard monitor for received bytes (R1)
   always @(negedge clk) begin
      if (rx_valid) begin
         if (rx_exp_q.size() == 0) begin
            chk(1'b0, "R1 unexpected rx_valid", 32'(rx_byte), 32'h0);
         end else begin
            logic [DW-1:0] e;
            e = rx_exp_q.pop_front();
            chk(rx_byte == e, "R1 received byte", 32'(rx_byte), 32'(e));
         end
      end
   end

   // kind: 0 none, 1 pause in low phase, 2 pause edges in high phase, 3 pause then deselect
   task automatic xfer(input logic [DW-1:0] mo, input int hold_bit, input int kind,
                       output logic [DW-1:0] got, output bit oe_any);
      bit pend = 1'b0;
      got = '0;
      oe_any = 1'b0;
      for (int i = DW-1; i >= 0; i--) begin
         sck = 1'b0;
         si  = mo[i];
         half();
         if (pend) begin
            chk(so_oe == 1'b0, "R7 pause starts at falling clock", 32'(so_oe), 32'h0);
            sck = 1'b1; si = ~mo[i];
            half();
            hold_n = 1'b1;
            half();
            chk(so_oe == 1'b0, "R8 pause held while clock high", 32'(so_oe), 32'h0);
            sck = 1'b0; si = mo[i];
            half();
            pend = 1'b0;
         end
         if ((kind == 1 || kind == 3) && hold_bit == i) begin
            hold_n = 1'b0;
            half();
            chk(so_oe == 1'b0, "R6 output released in pause", 32'(so_oe), 32'h0);
            if (kind == 3) begin
               cs_n = 1'b1;
               half();
               chk(so_oe == 1'b0, "R9 deselect during pause", 32'(so_oe), 32'h0);
               hold_n = 1'b1;
               half();
               return;
            end
            sck = 1'b1; si = ~mo[i];
            half();
            sck = 1'b0;
            half();
            hold_n = 1'b1; si = mo[i];
            half();
         end
         got[i] = so & so_oe;
         oe_any |= so_oe;
         sck = 1'b1;
         half();
         if (kind == 2 && hold_bit == i) begin
            hold_n = 1'b0;
            half();
            chk(so_oe == 1'b1, "R7 still driving while clock high", 32'(so_oe), 32'h1);
            pend = 1'b1;
         end
      end
   endtask

   task automatic txn(input bit m3, input logic [DW-1:0] b0, input logic [DW-1:0] b1,
                      input int nr, input logic [DW-1:0] r0, input logic [DW-1:0] r1,
                      input int hold_bit, input int kind, input string tag);
      logic [DW-1:0] got;
      bit oe_any;
      rx_exp_q.push_back(b0);
      rx_exp_q.push_back(b1);
      if (nr > 0) tx_q.push_back(r0);
      if (nr > 1) tx_q.push_back(r1);
      sck = m3;
      half();
      cs_n = 1'b0;
      half();
      xfer(b0, hold_bit, kind, got, oe_any);
      if (nr > 0) chk(got == r0, {tag, " first response byte"}, 32'(got), 32'(r0));
      else chk(got == '0 && !oe_any, {tag, " R4 no response driven"}, 32'(oe_any), 32'h0);
      xfer(b1, -1, 0, got, oe_any);
      if (nr > 1) chk(got == r1, {tag, " second response byte"}, 32'(got), 32'(r1));
      else chk(got == '0 && !oe_any, {tag, " R4 no response driven"}, 32'(oe_any), 32'h0);
      if (!m3) begin
         sck = 1'b0;
         half();
      end
      cs_n = 1'b1;
      half();
      chk(so_oe == 1'b0, {tag, " R5 released after deselect"}, 32'(so_oe), 32'h0);
      half();
   endtask

   // watchdog
   initial begin
      repeat (150000) @(posedge clk);
      chk(1'b0, "watchdog expired", 32'h0, 32'h1);
      summary();
      $finish;
   end

   int loads = 0;
   always @(negedge clk) if (tx_load) loads++;

   initial begin
      logic [DW-1:0] got;
      bit oe_any;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      chk(so_oe == 1'b0, "R5 reset output disabled", 32'(so_oe), 32'h0);
      chk(rx_valid == 1'b0, "R1 reset strobe low", 32'(rx_valid), 32'h0);
      chk(tx_load == 1'b0, "R4 reset load low", 32'(tx_load), 32'h0);

      // R1 R2: mode 0 traffic
      txn(1'b0, 8'hA5, 8'h3C, 2, 8'h96, 8'hF1, -1, 0, "R2 mode0");
      // R2 R3: mode 3 traffic, leading falling edge must not shift
      txn(1'b1, 8'h5A, 8'hC3, 2, 8'h0F, 8'h81, -1, 0, "R3 mode3");
      // R4: tx_load counted: four bytes taken so far
      chk(loads == 4, "R4 bytes taken", 32'(loads), 32'd4);
      // R4: nothing to send
      txn(1'b0, 8'h12, 8'hEF, 0, 8'h00, 8'h00, -1, 0, "R4 empty");
      chk(loads == 4, "R4 no load without tx_en", 32'(loads), 32'd4);
      // R6: pause in low phase, mode 0
      txn(1'b0, 8'h3A, 8'h6B, 2, 8'hC5, 8'h29, 4, 1, "R6 mode0 pause");
      // R6: pause in low phase, mode 3
      txn(1'b1, 8'hE1, 8'h0D, 2, 8'h5E, 8'hB3, 6, 1, "R6 mode3 pause");
      // R7 R8: pause edges in the high phase, both modes
      txn(1'b1, 8'h9C, 8'h47, 2, 8'hA6, 8'h1B, 5, 2, "R7 mode3 late pause");
      txn(1'b0, 8'h2D, 8'hF0, 2, 8'h6C, 8'h93, 3, 2, "R8 mode0 late pause");

      // R9: deselect during a pause discards the partial byte
      tx_q.push_back(8'h77);
      sck = 1'b0;
      half();
      cs_n = 1'b0;
      half();
      xfer(8'hFF, 3, 3, got, oe_any);
      half();
      txn(1'b0, 8'h81, 8'h7E, 2, 8'h42, 8'hD8, -1, 0, "R9 fresh after abort");

      repeat (20) @(negedge clk);
      chk(rx_exp_q.size() == 0, "R1 all bytes received", 32'(rx_exp_q.size()), 32'h0);
      summary();
      $finish;
   end

endmodule